// File: doc/BRIEF.md
# Ten-Bit Check Value Field Codec

This block moves the eight 10-bit check values of a 512-byte flash sector between the form an ECC engine uses and the ten-byte field kept in the page's spare area. In write (pack) mode it takes four 32-bit words. Each word carries two values, one in bits 9:0 and one in bits 25:16. It packs the eight values with no gaps and sends the resulting ten bytes out on a byte stream with valid/ready handshaking.

In read (unpack) mode it takes the ten stored bytes from a byte stream. A field in which every byte is 0xFF belongs to an erased page. Such a field is reported with an erased flag, and nothing is sent on to the syndrome engine. Any other field is unpacked and placed on a load port, one value per cycle, highest index first, so that an external syndrome engine can take the expected values in the order it needs.

Each frame ends with a single-cycle done pulse. The block runs one frame at a time. The mode input is sampled only when a frame starts.

Top module: `ecc_oob_codec`

## Requirements
- R1: A synchronous active-high reset returns the block to idle from any point in a frame: `ob_valid`, `ld_valid`, `done`, `done_erased`, `wr_word_ready` and `ib_ready` are low. The next frame starts with word 0 or byte 0.
- R2: In pack mode the block accepts exactly four words. Word k gives value 2k from its bits 9:0 and value 2k+1 from its bits 25:16. All other word bits are ignored.
- R3: The packed field is 80 bits wide, with value v in field bits 10v+9 down to 10v. It is sent as ten bytes, byte b being field bits 8b+7 down to 8b, and byte 0 goes first. Each group of four values therefore fills exactly five bytes.
- R4: While `ob_valid` is high and `ob_ready` is low, `ob_valid` stays high and `ob_data` does not change.
- R5: In unpack mode the block accepts exactly ten bytes. When all ten equal 0xFF, `ld_valid` never rises for that frame, and `done` is raised together with `done_erased`.
- R6: Any other field is unpacked with the inverse of the R3 layout. The eight values appear on `ld_data` with `ld_valid` high in eight consecutive cycles, `ld_idx` counting down from 7 to 0 and naming the value shown.
- R7: The mode (`mode_rd` = 1 for unpack) is sampled in the idle cycle in which the valid of the matching input stream is seen. A change of `mode_rd` later in the frame has no effect. Both input readies stay low until the frame has ended.
- R8: `done` is high for exactly one cycle per frame. In pack mode it follows the last byte handshake by one cycle. In unpack mode it comes with the last load value, or one cycle after the tenth byte for an erased field. `done_erased` is high only with `done` of an erased field.
- R9: A field that differs from all-0xFF in a single bit, in any byte including byte 0, is not erased and is unpacked normally. An erased field seen earlier does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_rd | input | 1 | 0 = pack words to bytes, 1 = unpack bytes to values |
| wr_word | input | WORD_W | Word carrying two check values |
| wr_word_valid | input | 1 | Word stream valid |
| wr_word_ready | output | 1 | Word stream ready |
| ob_data | output | 8 | Packed field byte |
| ob_valid | output | 1 | Byte output valid |
| ob_ready | input | 1 | Byte output ready |
| ib_data | input | 8 | Stored field byte |
| ib_valid | input | 1 | Byte input valid |
| ib_ready | output | 1 | Byte input ready |
| ld_valid | output | 1 | Load port value valid |
| ld_data | output | VAL_W | Unpacked check value |
| ld_idx | output | clog2(VALS) | Index of the value on `ld_data` |
| done | output | 1 | End-of-frame pulse |
| done_erased | output | 1 | Field was erased (valid with `done`) |

## Verification
The hardest case to reach from the ports is the erased-field decision. It depends on every byte of the frame, and the decision for the last byte is taken in the same cycle that byte arrives. The stimulus reaches it in three ways. It round-trips a packed field whose values are all 0x3FF, which produces an all-0xFF field. It sends fields that are all 0xFF except for one cleared bit, placed once in byte 0 and once in a middle byte. It sends an erased frame directly before a normal one, so that a flag left over from one frame into the next would show. Reset is also applied in the middle of both a pack frame and an unpack frame, and the frame sent afterwards shows whether the counters were cleared.

// File: rtl/ecc_oob_pkg.sv
package ecc_oob_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_EMIT,
    ST_COLLECT,
    ST_LOAD
  } codec_st_e;
endpackage

// File: rtl/ecc_field_store.sv
// Holds the packed 80-bit field. Words write two values at a time,
// bytes write eight field bits at a time; reads are by byte or by value.
module ecc_field_store #(
  parameter int VAL_W  = 10,
  parameter int VALS   = 8,
  parameter int WORD_W = 32,
  parameter int HI_LSB = 16,
  localparam int FIELD_W = VAL_W * VALS,
  localparam int NBYTES  = FIELD_W / 8,
  localparam int NWORDS  = VALS / 2,
  localparam int WIW     = $clog2(NWORDS),
  localparam int BIW     = $clog2(NBYTES),
  localparam int VIW     = $clog2(VALS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_en,
  input  logic [WIW-1:0]    wd_idx,
  input  logic [WORD_W-1:0] wd,
  input  logic              bw_en,
  input  logic [BIW-1:0]    bw_idx,
  input  logic [7:0]        bw,
  input  logic [BIW-1:0]    rb_idx,
  output logic [7:0]        rb,
  input  logic [VIW-1:0]    rv_idx,
  output logic [VAL_W-1:0]  rv
);
  localparam logic [WORD_W-1:0] LO_MASK  = (WORD_W'(1) << VAL_W) - WORD_W'(1);
  localparam logic [WORD_W-1:0] VAL_MASK = LO_MASK | (LO_MASK << HI_LSB);

  logic [FIELD_W-1:0] fld;
  logic [7:0]         byte_arr [NBYTES];
  logic [VAL_W-1:0]   val_arr  [VALS];
  logic               unused_word_bits;

  // bits outside the two value slots carry nothing
  assign unused_word_bits = ^(wd & ~VAL_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      fld <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (wd_en && wd_idx == WIW'(w))
          fld[w*2*VAL_W +: 2*VAL_W] <= {wd[HI_LSB +: VAL_W], wd[VAL_W-1:0]};
      end
      for (int b = 0; b < NBYTES; b++) begin
        if (bw_en && bw_idx == BIW'(b))
          fld[b*8 +: 8] <= bw;
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign byte_arr[g] = fld[g*8 +: 8];
  end
  for (genvar g = 0; g < VALS; g++) begin : g_vals
    assign val_arr[g] = fld[g*VAL_W +: VAL_W];
  end

  assign rb = byte_arr[rb_idx];
  assign rv = val_arr[rv_idx];

  AST_BYTE_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    bw_en |-> int'(bw_idx) < NBYTES); // R5
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(wd_en && bw_en)); // R7
endmodule

// File: rtl/ecc_erase_det.sv
// Tracks whether every byte of the incoming field so far is 0xFF.
module ecc_erase_det (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       first,
  input  logic [7:0] din,
  output logic       field_ff
);
  logic all_ff_q;

  assign field_ff = (first | all_ff_q) & (din == 8'hFF);

  always_ff @(posedge clk) begin
    if (rst)     all_ff_q <= 1'b0;
    else if (en) all_ff_q <= field_ff;
  end

  AST_NON_FF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    en && din != 8'hFF |=> !all_ff_q); // R9
endmodule

// File: rtl/ecc_oob_codec.sv
module ecc_oob_codec
  import ecc_oob_pkg::*;
#(
  parameter int VAL_W  = 10,
  parameter int VALS   = 8,
  parameter int WORD_W = 32,
  parameter int HI_LSB = 16,
  localparam int VIW   = $clog2(VALS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rd,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_word_valid,
  output logic              wr_word_ready,
  output logic [7:0]        ob_data,
  output logic              ob_valid,
  input  logic              ob_ready,
  input  logic [7:0]        ib_data,
  input  logic              ib_valid,
  output logic              ib_ready,
  output logic              ld_valid,
  output logic [VAL_W-1:0]  ld_data,
  output logic [VIW-1:0]    ld_idx,
  output logic              done,
  output logic              done_erased
);
  localparam int FIELD_W = VAL_W * VALS;
  localparam int NBYTES  = FIELD_W / 8;
  localparam int NWORDS  = VALS / 2;
  localparam int WIW     = $clog2(NWORDS);
  localparam int BIW     = $clog2(NBYTES);
  localparam logic [WIW-1:0] LAST_W = WIW'(NWORDS - 1);
  localparam logic [BIW-1:0] LAST_B = BIW'(NBYTES - 1);
  localparam logic [VIW-1:0] LAST_V = VIW'(VALS - 1);

  codec_st_e        st;
  logic [WIW-1:0]   word_cnt;
  logic [BIW-1:0]   byte_cnt;
  logic [VIW-1:0]   val_cnt;
  logic             w_hs, i_hs, o_hs;
  logic [VAL_W-1:0] rv;
  logic             field_ff;
  logic             ld_valid_q, done_q, er_q;
  logic [VAL_W-1:0] ld_data_q;
  logic [VIW-1:0]   ld_idx_q;

  assign wr_word_ready = (st == ST_GATHER);
  assign ib_ready      = (st == ST_COLLECT);
  assign ob_valid      = (st == ST_EMIT);
  assign w_hs = wr_word_valid & wr_word_ready;
  assign i_hs = ib_valid & ib_ready;
  assign o_hs = ob_valid & ob_ready;

  ecc_field_store #(
    .VAL_W(VAL_W), .VALS(VALS), .WORD_W(WORD_W), .HI_LSB(HI_LSB)
  ) u_store (
    .clk(clk), .rst(rst),
    .wd_en(w_hs), .wd_idx(word_cnt), .wd(wr_word),
    .bw_en(i_hs), .bw_idx(byte_cnt), .bw(ib_data),
    .rb_idx(byte_cnt), .rb(ob_data),
    .rv_idx(val_cnt), .rv(rv)
  );

  ecc_erase_det u_erase (
    .clk(clk), .rst(rst), .en(i_hs),
    .first(byte_cnt == '0), .din(ib_data), .field_ff(field_ff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      word_cnt   <= '0;
      byte_cnt   <= '0;
      val_cnt    <= '0;
      ld_valid_q <= 1'b0;
      ld_data_q  <= '0;
      ld_idx_q   <= '0;
      done_q     <= 1'b0;
      er_q       <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      er_q       <= 1'b0;
      ld_valid_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          word_cnt <= '0;
          byte_cnt <= '0;
          if (mode_rd && ib_valid)            st <= ST_COLLECT;
          else if (!mode_rd && wr_word_valid) st <= ST_GATHER;
        end
        ST_GATHER: if (w_hs) begin
          if (word_cnt == LAST_W) begin
            st       <= ST_EMIT;
            byte_cnt <= '0;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end
        ST_EMIT: if (o_hs) begin
          if (byte_cnt == LAST_B) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_COLLECT: if (i_hs) begin
          if (byte_cnt == LAST_B) begin
            if (field_ff) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
              er_q   <= 1'b1;
            end else begin
              st      <= ST_LOAD;
              val_cnt <= LAST_V;
            end
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          ld_valid_q <= 1'b1;
          ld_data_q  <= rv;
          ld_idx_q   <= val_cnt;
          if (val_cnt == '0) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            val_cnt <= val_cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ld_valid    = ld_valid_q;
  assign ld_data     = ld_data_q;
  assign ld_idx      = ld_idx_q;
  assign done        = done_q;
  assign done_erased = er_q;

  AST_EMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ob_valid && !ob_ready |=> ob_valid && $stable(ob_data)); // R4
  AST_ERASED_SILENT: assert property (@(posedge clk) disable iff (rst)
    done_erased |-> done && !ld_valid); // R5
  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_valid) |-> ld_idx == LAST_V); // R6
  AST_LOAD_STEP: assert property (@(posedge clk) disable iff (rst)
    ld_valid && ld_idx != '0 |=> ld_valid && ld_idx == $past(ld_idx) - 1'b1); // R6
  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (ob_valid || ld_valid) |-> !wr_word_ready && !ib_ready); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_LOAD_END: assert property (@(posedge clk) disable iff (rst)
    ld_valid && ld_idx == '0 |-> done && !done_erased); // R8
endmodule

// File: tb/ecc_oob_codec_bench.sv
`timescale 1ns/1ps
module ecc_oob_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_rd = 1'b0;
  logic [31:0] wr_word = '0;
  logic        wr_word_valid = 1'b0;
  logic        wr_word_ready;
  logic [7:0]  ob_data;
  logic        ob_valid;
  logic        ob_ready = 1'b0;
  logic [7:0]  ib_data = '0;
  logic        ib_valid = 1'b0;
  logic        ib_ready;
  logic        ld_valid;
  logic [9:0]  ld_data;
  logic [2:0]  ld_idx;
  logic        done;
  logic        done_erased;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ecc_oob_codec u_ecc_oob_codec (
    .clk(clk), .rst(rst), .mode_rd(mode_rd),
    .wr_word(wr_word), .wr_word_valid(wr_word_valid), .wr_word_ready(wr_word_ready),
    .ob_data(ob_data), .ob_valid(ob_valid), .ob_ready(ob_ready),
    .ib_data(ib_data), .ib_valid(ib_valid), .ib_ready(ib_ready),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_idx(ld_idx),
    .done(done), .done_erased(done_erased)
  );

  localparam int NVEC = 6;
  localparam logic [79:0] VEC [NVEC] = '{
    80'h0000_0000_0000_0000_0000,
    80'hFFFF_FFFF_FFFF_FFFF_FFFF,
    80'h0123_4567_89AB_CDEF_0123,
    80'h8000_0000_0000_0000_0001,
    80'hA5A5_5A5A_C3C3_3C3C_0FF0,
    80'hFFC0_0000_0000_0000_0000
  };

  // load-port and done monitor
  int         cyc = 0;
  int         ld_n = 0;
  logic [9:0] ld_vals [16];
  int         ld_ids  [16];
  int         ld_cyc  [16];
  int         done_n = 0;
  int         done_cyc = 0;
  bit         last_er = 0;

  always @(negedge clk) begin
    cyc++;
    if (ld_valid && ld_n < 16) begin
      ld_vals[ld_n] = ld_data;
      ld_ids[ld_n]  = int'(ld_idx);
      ld_cyc[ld_n]  = cyc;
      ld_n++;
    end
    if (done) begin
      done_n++;
      done_cyc = cyc;
      last_er  = done_erased;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // junk in the unused word bits tests the masking of R2
  function automatic logic [31:0] mk_word(input logic [79:0] f, input int k);
    logic [5:0] j;
    j = 6'h2A ^ 6'(k);
    return {j, f[20*k+10 +: 10], ~j, f[20*k +: 10]};
  endfunction

  task automatic put_word(input logic [31:0] w);
    wr_word = w; wr_word_valid = 1'b1; #1;
    while (!wr_word_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_word_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    ib_data = b; ib_valid = 1'b1; #1;
    while (!ib_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ib_valid = 1'b0;
  endtask

  task automatic write_frame(input logic [79:0] f, input bit stall, input bit flip);
    logic [7:0] held;
    int d0;
    d0 = done_n;
    ld_n = 0;
    mode_rd = 1'b0;
    for (int k = 0; k < 4; k++) begin
      put_word(mk_word(f, k));
      if (flip && k == 0) begin mode_rd = 1'b1; ib_valid = 1'b1; ib_data = 8'h55; end
    end
    for (int b = 0; b < 10; b++) begin
      if (flip && b == 9) begin mode_rd = 1'b0; ib_valid = 1'b0; end
      ob_ready = 1'b1; #1;
      while (!ob_valid) begin @(negedge clk); #1; end
      if (flip && b == 5)
        chk(!ib_ready && !wr_word_ready, "R7", "readies open mid-frame",
            {ib_ready, wr_word_ready}, 0);
      chk(ob_data == f[8*b +: 8], "R3", $sformatf("byte %0d", b), ob_data, f[8*b +: 8]);
      if (stall && b == 3) begin
        ob_ready = 1'b0; held = ob_data;
        repeat (3) begin
          @(negedge clk); #1;
          chk(ob_valid && ob_data == held, "R4", "stalled byte", ob_data, held);
        end
        ob_ready = 1'b1;
      end
      @(negedge clk);
    end
    ob_ready = 1'b0; #1;
    chk(done && !done_erased, "R8", "pack done after last byte", {done, done_erased}, 2);
    @(negedge clk);
    chk(done_n == d0 + 1, "R8", "pack done count", done_n - d0, 1);
    chk(ld_n == 0, "R2", "loads during pack", ld_n, 0);
  endtask

  task automatic read_frame(input logic [79:0] f, input string req);
    int d0;
    bit er;
    d0 = done_n;
    ld_n = 0;
    er = (f == {80{1'b1}});
    mode_rd = 1'b1;
    for (int b = 0; b < 10; b++) put_byte(f[8*b +: 8]);
    mode_rd = 1'b0;
    repeat (12) @(negedge clk);
    #1;
    chk(done_n == d0 + 1, "R8", "unpack done count", done_n - d0, 1);
    if (er) begin
      chk(ld_n == 0, "R5", "loads on erased field", ld_n, 0);
      chk(last_er, "R5", "erased flag", last_er, 1);
    end else begin
      chk(!last_er, req, "erased flag on written field", last_er, 0);
      chk(ld_n == 8, "R6", "load count", ld_n, 8);
      if (ld_n == 8) begin
        for (int j = 0; j < 8; j++) begin
          chk(ld_ids[j] == 7 - j, "R6", "load order", ld_ids[j], 7 - j);
          chk(ld_vals[j] == f[10*(7-j) +: 10], req, $sformatf("value %0d", 7 - j),
              ld_vals[j], f[10*(7-j) +: 10]);
          chk(ld_cyc[j] == ld_cyc[0] + j, "R6", "consecutive loads", ld_cyc[j], ld_cyc[0] + j);
        end
        chk(done_cyc == ld_cyc[7], "R8", "done with last value", done_cyc, ld_cyc[7]);
      end
    end
  endtask

  task automatic check_idle(input string what);
    #1;
    chk(!ob_valid && !ld_valid && !done && !done_erased && !wr_word_ready && !ib_ready,
        "R1", what, {ob_valid, ld_valid, done, done_erased, wr_word_ready, ib_ready}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_idle("outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("idle after reset");

    // table walk: pack each vector, then unpack the resulting bytes (R2 R3 R5 R6)
    for (int i = 0; i < NVEC; i++) begin
      write_frame(VEC[i], i == 2, 1'b0);
      read_frame(VEC[i], "R6");
    end

    // mode changes mid pack frame are ignored (R7)
    write_frame(VEC[4], 1'b0, 1'b1);

    // single cleared bit: byte 0 and a middle byte (R9)
    read_frame(80'hFFFF_FFFF_FFFF_FFFF_FF7F, "R9");
    read_frame(80'hFFFF_FFFE_FFFF_FFFF_FFFF, "R9");
    // erased directly followed by written field (R9)
    read_frame(VEC[1], "R5");
    read_frame(VEC[3], "R9");

    // reset during a pack frame (R1)
    mode_rd = 1'b0;
    put_word(mk_word(VEC[3], 0));
    put_word(mk_word(VEC[3], 1));
    rst = 1'b1;
    @(negedge clk);
    check_idle("reset mid pack");
    rst = 1'b0;
    write_frame(VEC[2], 1'b0, 1'b0);

    // reset during an unpack frame (R1)
    mode_rd = 1'b1;
    for (int b = 0; b < 4; b++) put_byte(8'h12 + 8'(b));
    rst = 1'b1;
    @(negedge clk);
    check_idle("reset mid unpack");
    rst = 1'b0;
    mode_rd = 1'b0;
    read_frame(VEC[2], "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule